// File: doc/BRIEF.md
# Serial Configuration Stream Framing Checker

This block takes a configuration stream one bit at a time and checks that it is well formed. A bit source feeds it: either a serial bit with a per-clock enable, or a byte-wide port whose bytes are turned into serial bits, least significant bit first. The parser searches the incoming bits for a fill-and-preamble pattern. It then captures a 24-bit length word and checks a run of separator ones. After that it splits the payload into a fixed number of fixed-size frames.

Each frame carries a trailing 4-bit check field. Depending on a mode input, that field is compared with a fixed constant or with the low bits of a running CRC-16. After the last frame the block expects a closing byte. It also checks that the length word equals the number of bits it actually received. It then counts a few start-up bits before raising done. Any framing fault moves the parser into a fault state. In that state the active-low error output stays low, no further frames are reported, and all input is ignored until the synchronous reset is pulsed.

Top module: `cfg_stream_parser`

## Requirements
- R1: The header is the 12-bit sequence of eight 1 bits followed by 0,0,1,0, in arrival order. Any other bits before it, including runs of fewer than eight ones or a wrong nibble after the ones, are skipped. Skipped bits raise no error, and the parser keeps searching.
- R2: The 24 bits after the header are shifted into `length_count`, the first bit received landing in bit 23.
- R3: The 4 bits after the length word must all be 1. A 0 there drives `err_n` low.
- R4: Each frame opens with one bit that must be 0. A 1 in that position drives `err_n` low.
- R5: When `crc_mode` is 0, the 4-bit check field after each frame's FRAME_BITS data bits must arrive as 0,1,1,0. Any differing bit drives `err_n` low.
- R6: When `crc_mode` is 1, a CRC-16 is used, with generator 0x8005, cleared to zero during the separator and advanced by data bits only. The check field must carry its bits 3,2,1,0 in that order, taken after the frame's last data bit. Any mismatch drives `err_n` low.
- R7: One cycle after a frame's fourth check bit is accepted with no mismatch, `frame_valid` is high for exactly one cycle. At the same time `frame_data` holds the frame's data bits, the first received in the MSB.
- R8: After NUM_FRAMES frames, the next 8 bits must be 0 followed by seven 1s. The length word must equal the number of bits received from the first frame's start bit through the last bit of that byte. Either mismatch drives `err_n` low.
- R9: After the closing byte, `done` rises one cycle after the STARTUP_CLKS-th further accepted bit, whatever the values of those bits. It then stays high until reset.
- R10: Once `err_n` is low, it stays low until `rst`. While it is low, `frame_valid` and `done` stay low whatever the input. A reset returns `err_n` high, `done` and `frame_valid` low and `length_count` to zero.
- R11: When `byte_mode` is 1, a byte offered on `byte_valid` is accepted only if at most one bit of the previous byte is still pending. The byte's bits are delivered on the following eight clocks, bit 0 first. Offers made while the previous byte is still being shifted are ignored, and `bit_en` has no effect in this mode.
- R12: When `byte_mode` is 0 and `bit_en` is 0, no output changes on that clock, whatever `bit_in` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset and restart of loading |
| crc_mode | input | 1 | 1 selects CRC check fields, 0 the constant check field |
| byte_mode | input | 1 | 1 takes bits from the byte port, 0 from the serial port |
| bit_en | input | 1 | Serial bit qualifier |
| bit_in | input | 1 | Serial bit |
| byte_valid | input | 1 | Offers `byte_in` in byte mode |
| byte_in | input | 8 | Byte of stream, bit 0 sent first |
| frame_data | output | FRAME_BITS | Data bits of the last frame that passed its check |
| frame_valid | output | 1 | One-cycle strobe for a passed frame |
| length_count | output | 24 | Captured length word |
| err_n | output | 1 | Low after a framing fault |
| done | output | 1 | High once start-up bits have been counted |

## Verification
The bench goes after look-alike headers: seven ones before a real preamble and eight ones before a wrong nibble. A detector with a short window or a loose run counter would lock onto these and mis-frame everything after them. It corrupts, one at a time, the separator, a start bit, a constant check field, a CRC check field, the closing byte and the length word. A design that misses any of these would raise `done` or keep strobing frames instead of holding `err_n` low. It stops one bit short of the start-up count and inserts gaps with a toggling `bit_in`, which expose an off-by-one in the start-up counter or bits sampled without their enable. In byte mode it offers an extra byte while one is still being shifted, so a serializer that accepts it, or that sends bit 7 first, corrupts every frame.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    typedef enum logic [3:0] {
        PH_HUNT,
        PH_LEN,
        PH_SEP,
        PH_START,
        PH_DATA,
        PH_CHECK,
        PH_POST,
        PH_STARTUP,
        PH_DONE,
        PH_FAULT
    } phase_e;

    typedef struct packed {
        logic valid;
        logic data;
    } sbit_t;

    localparam int          FILL_BITS = 8;
    localparam int          PRE_BITS  = 4;
    localparam logic [3:0]  PREAMBLE  = 4'b0010;
    localparam int          LEN_BITS  = 24;
    localparam int          SEP_BITS  = 4;
    localparam int          CHK_BITS  = 4;
    localparam logic [3:0]  CHK_CONST = 4'b0110;
    localparam int          POST_BITS = 8;
    localparam logic [7:0]  POSTAMBLE = 8'b0111_1111;
    localparam int          CRC_W     = 16;
    localparam logic [15:0] CRC_POLY  = 16'h8005;
    localparam int          BYTE_W    = 8;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [CRC_W-1:0] crc_advance(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = b ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/cfg_bit_source.sv
module cfg_bit_source
    import cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_mode,
    input  logic              bit_en,
    input  logic              bit_in,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_in,
    output sbit_t             bit_o
);
    localparam int LW = $clog2(BYTE_W + 1);

    logic [BYTE_W-1:0] shift_q;
    logic [LW-1:0]     left_q;
    logic              can_load;

    assign can_load = (left_q <= LW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            left_q  <= '0;
        end else if (byte_mode && byte_valid && can_load) begin
            shift_q <= byte_in;
            left_q  <= LW'(BYTE_W);
        end else if (left_q != '0) begin
            shift_q <= shift_q >> 1;
            left_q  <= left_q - 1'b1;
        end
    end

    always_comb begin
        if (byte_mode) begin
            bit_o.valid = (left_q != '0);
            bit_o.data  = shift_q[0];
        end else begin
            bit_o.valid = bit_en;
            bit_o.data  = bit_in;
        end
    end
endmodule

// File: rtl/cfg_header_detect.sv
module cfg_header_detect
    import cfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hunt,
    input  sbit_t bit_i,
    output logic  found
);
    localparam int WIN = FILL_BITS + PRE_BITS;
    localparam logic [WIN-1:0] PATTERN = {{FILL_BITS{1'b1}}, PREAMBLE};

    logic [WIN-2:0] win_q;
    logic [WIN-1:0] view;

    assign view  = {win_q, bit_i.data};
    assign found = hunt && bit_i.valid && (view == PATTERN);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
        end else if (hunt && bit_i.valid) begin
            win_q <= view[WIN-2:0];
        end
    end
endmodule

// File: rtl/cfg_crc16.sv
module cfg_crc16
    import cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                shift,
    input  logic                din,
    output logic [CHK_BITS-1:0] tag
);
    logic [CRC_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            crc_q <= '0;
        end else if (shift) begin
            crc_q <= crc_advance(crc_q, din);
        end
    end

    assign tag = crc_q[CHK_BITS-1:0];
endmodule

// File: rtl/cfg_stream_parser.sv
module cfg_stream_parser
    import cfg_pkg::*;
#(
    parameter int FRAME_BITS   = 8,
    parameter int NUM_FRAMES   = 3,
    parameter int STARTUP_CLKS = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  crc_mode,
    input  logic                  byte_mode,
    input  logic                  bit_en,
    input  logic                  bit_in,
    input  logic                  byte_valid,
    input  logic [BYTE_W-1:0]     byte_in,
    output logic [FRAME_BITS-1:0] frame_data,
    output logic                  frame_valid,
    output logic [LEN_BITS-1:0]   length_count,
    output logic                  err_n,
    output logic                  done
);
    localparam int CMAX = imax(imax(LEN_BITS, FRAME_BITS), imax(STARTUP_CLKS, POST_BITS));
    localparam int CW   = $clog2(CMAX) + 1;
    localparam int FW   = $clog2(NUM_FRAMES + 1);

    sbit_t                 sb;
    logic                  hdr_found;
    logic [CHK_BITS-1:0]   crc_tag;
    logic [CHK_BITS-1:0]   exp_nib;
    phase_e                phase_q;
    logic [CW-1:0]         cnt_q;
    logic [FW-1:0]         frm_q;
    logic [LEN_BITS-1:0]   total_q;
    logic [LEN_BITS-1:0]   len_q;
    logic [FRAME_BITS-1:0] word_q;
    logic [FRAME_BITS-1:0] fdata_q;
    logic                  fv_q;
    logic                  chk_bad;
    logic                  post_bad;

    cfg_bit_source u_src (
        .clk        (clk),
        .rst        (rst),
        .byte_mode  (byte_mode),
        .bit_en     (bit_en),
        .bit_in     (bit_in),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .bit_o      (sb)
    );

    cfg_header_detect u_hdr (
        .clk   (clk),
        .rst   (rst),
        .hunt  (phase_q == PH_HUNT),
        .bit_i (sb),
        .found (hdr_found)
    );

    cfg_crc16 u_crc (
        .clk   (clk),
        .rst   (rst),
        .clear (sb.valid && phase_q == PH_SEP),
        .shift (sb.valid && phase_q == PH_DATA),
        .din   (sb.data),
        .tag   (crc_tag)
    );

    assign exp_nib  = crc_mode ? crc_tag : CHK_CONST;
    assign chk_bad  = (sb.data != exp_nib[2'd3 - cnt_q[1:0]]);
    assign post_bad = (sb.data != POSTAMBLE[3'd7 - cnt_q[2:0]]);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_HUNT;
            cnt_q   <= '0;
            frm_q   <= '0;
            total_q <= '0;
            len_q   <= '0;
            word_q  <= '0;
            fdata_q <= '0;
            fv_q    <= 1'b0;
        end else begin
            fv_q <= 1'b0;
            if (sb.valid) begin
                unique case (phase_q)
                    PH_HUNT: begin
                        if (hdr_found) begin
                            phase_q <= PH_LEN;
                            cnt_q   <= '0;
                        end
                    end
                    PH_LEN: begin
                        len_q <= {len_q[LEN_BITS-2:0], sb.data};
                        if (cnt_q == CW'(LEN_BITS - 1)) begin
                            phase_q <= PH_SEP;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_SEP: begin
                        if (!sb.data) begin
                            phase_q <= PH_FAULT;
                        end else if (cnt_q == CW'(SEP_BITS - 1)) begin
                            phase_q <= PH_START;
                            cnt_q   <= '0;
                            total_q <= '0;
                            frm_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_START: begin
                        total_q <= total_q + 1'b1;
                        if (sb.data) begin
                            phase_q <= PH_FAULT;
                        end else begin
                            phase_q <= PH_DATA;
                            cnt_q   <= '0;
                        end
                    end
                    PH_DATA: begin
                        total_q <= total_q + 1'b1;
                        word_q  <= {word_q[FRAME_BITS-2:0], sb.data};
                        if (cnt_q == CW'(FRAME_BITS - 1)) begin
                            phase_q <= PH_CHECK;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_CHECK: begin
                        total_q <= total_q + 1'b1;
                        if (chk_bad) begin
                            phase_q <= PH_FAULT;
                        end else if (cnt_q == CW'(CHK_BITS - 1)) begin
                            fv_q    <= 1'b1;
                            fdata_q <= word_q;
                            cnt_q   <= '0;
                            frm_q   <= frm_q + 1'b1;
                            phase_q <= (frm_q == FW'(NUM_FRAMES - 1)) ? PH_POST : PH_START;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_POST: begin
                        total_q <= total_q + 1'b1;
                        if (post_bad) begin
                            phase_q <= PH_FAULT;
                        end else if (cnt_q == CW'(POST_BITS - 1)) begin
                            cnt_q   <= '0;
                            phase_q <= (len_q != total_q + 1'b1) ? PH_FAULT : PH_STARTUP;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_STARTUP: begin
                        if (cnt_q == CW'(STARTUP_CLKS - 1)) begin
                            phase_q <= PH_DONE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign frame_data   = fdata_q;
    assign frame_valid  = fv_q;
    assign length_count = len_q;
    assign err_n        = (phase_q != PH_FAULT);
    assign done         = (phase_q == PH_DONE);
endmodule

// File: rtl/cfg_stream_parser_chk.sv
module cfg_stream_parser_chk (
    input logic        clk,
    input logic        rst,
    input logic        byte_mode,
    input logic        bit_en,
    input logic        frame_valid,
    input logic [23:0] length_count,
    input logic        err_n,
    input logic        done
);
    // R10
    err_latched_chk: assert property (@(posedge clk) disable iff (rst)
        !err_n |=> !err_n);

    // R10
    no_strobe_in_fault_chk: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> err_n);

    // R7
    single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        frame_valid |=> !frame_valid);

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R10
    done_clean_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> err_n);

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!byte_mode && !bit_en) |=>
            (!frame_valid && $stable(length_count) && $stable(err_n) && $stable(done)));
endmodule

bind cfg_stream_parser cfg_stream_parser_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .byte_mode    (byte_mode),
    .bit_en       (bit_en),
    .frame_valid  (frame_valid),
    .length_count (length_count),
    .err_n        (err_n),
    .done         (done)
);

// File: tb/cfg_stream_parser_tb.sv
module cfg_stream_parser_tb;
    localparam int FB     = 8;
    localparam int NF     = 3;
    localparam int SU     = 4;
    localparam int LEN_OK = NF * (FB + 5) + 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          crc_mode = 1'b0;
    logic          byte_mode = 1'b0;
    logic          bit_en = 1'b0;
    logic          bit_in = 1'b0;
    logic          byte_valid = 1'b0;
    logic [7:0]    byte_in = 8'h00;
    logic [FB-1:0] frame_data;
    logic          frame_valid;
    logic [23:0]   length_count;
    logic          err_n;
    logic          done;

    int checks = 0;
    int fails = 0;
    int strobes = 0;
    int cycles = 0;
    bit started = 0;

    always #10 clk = ~clk;

    cfg_stream_parser #(.FRAME_BITS(FB), .NUM_FRAMES(NF), .STARTUP_CLKS(SU)) u_dut (
        .clk(clk), .rst(rst), .crc_mode(crc_mode), .byte_mode(byte_mode),
        .bit_en(bit_en), .bit_in(bit_in), .byte_valid(byte_valid), .byte_in(byte_in),
        .frame_data(frame_data), .frame_valid(frame_valid), .length_count(length_count),
        .err_n(err_n), .done(done)
    );

    task automatic expect_eq(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    function automatic logic [15:0] crc_tb(input logic [15:0] c, input logic b);
        logic [15:0] n;
        n = c << 1;
        if (b != c[15]) n = n ^ 16'h8005;
        return n;
    endfunction

    // behavioural reference model
    bit            sq[$];
    bit            win[$];
    bit            stim[$];
    int            m_ph, m_pos, m_bits, m_fr;
    bit            m_err, m_done, m_fv;
    logic [15:0]   m_crc;
    logic [23:0]   m_len;
    logic [FB-1:0] m_dw, m_data;

    function automatic bit header_seen();
        bit ok;
        ok = (win.size() == 12);
        for (int i = 0; i < 12 && ok; i++) begin
            if (i < 8) ok = (win[i] == 1'b1);
            else ok = (win[i] == ((i == 10) ? 1'b1 : 1'b0));
        end
        return ok;
    endfunction

    task automatic model_reset();
        sq.delete(); win.delete();
        m_ph = 0; m_pos = 0; m_bits = 0; m_fr = 0;
        m_err = 0; m_done = 0; m_fv = 0;
        m_crc = '0; m_len = '0; m_dw = '0; m_data = '0;
    endtask

    task automatic model_step();
        bit have, b;
        logic [3:0] nib;
        logic [7:0] post;
        post = 8'h7F;
        m_fv = 0; have = 0; b = 0;
        if (byte_mode) begin
            if (sq.size() > 0) begin b = sq.pop_front(); have = 1; end
            if (byte_valid && sq.size() == 0)
                for (int k = 0; k < 8; k++) sq.push_back(byte_in[k]);
        end else if (bit_en) begin
            b = bit_in; have = 1;
        end
        if (!have || m_err) return;
        case (m_ph)
            0: begin
                win.push_back(b);
                if (win.size() > 12) void'(win.pop_front());
                if (header_seen()) begin m_ph = 1; m_pos = 0; end
            end
            1: begin
                m_len = {m_len[22:0], b}; m_pos++;
                if (m_pos == 24) begin m_ph = 2; m_pos = 0; end
            end
            2: begin
                if (!b) m_err = 1;
                else begin
                    m_pos++;
                    if (m_pos == 4) begin m_ph = 3; m_crc = '0; m_bits = 0; m_fr = 0; end
                end
            end
            3: begin
                m_bits++;
                if (b) m_err = 1; else begin m_ph = 4; m_pos = 0; end
            end
            4: begin
                m_bits++;
                m_dw = {m_dw[FB-2:0], b};
                m_crc = crc_tb(m_crc, b);
                m_pos++;
                if (m_pos == FB) begin m_ph = 5; m_pos = 0; end
            end
            5: begin
                m_bits++;
                nib = crc_mode ? m_crc[3:0] : 4'b0110;
                if (b != nib[3 - m_pos]) m_err = 1;
                else begin
                    m_pos++;
                    if (m_pos == 4) begin
                        m_fv = 1; m_data = m_dw; m_fr++; m_pos = 0;
                        m_ph = (m_fr == NF) ? 6 : 3;
                    end
                end
            end
            6: begin
                m_bits++;
                if (b != post[7 - m_pos]) m_err = 1;
                else begin
                    m_pos++;
                    if (m_pos == 8) begin
                        if (int'(m_len) != m_bits) m_err = 1;
                        else begin m_ph = 7; m_pos = 0; end
                    end
                end
            end
            7: begin
                m_pos++;
                if (m_pos == SU) begin m_done = 1; m_ph = 8; end
            end
            default: ;
        endcase
    endtask

    always @(posedge clk) begin
        if (rst) begin
            model_reset();
            started = 1;
        end else begin
            model_step();
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
        if (started && !rst) begin
            if (frame_valid) strobes++;
            expect_eq("R10 err_n per cycle", err_n, !m_err);
            expect_eq("R9 done per cycle", done, m_done);
            expect_eq("R7 frame_valid per cycle", frame_valid, m_fv);
            expect_eq("R7 frame_data per cycle", frame_data, m_data);
            expect_eq("R2 length_count per cycle", length_count, m_len);
        end
    end

    // stimulus helpers
    task automatic push_field(input logic [31:0] v, input int w);
        for (int i = w - 1; i >= 0; i--) stim.push_back(v[i]);
    endtask

    // fault: 0 none, 1 start bit, 2 crc nibble, 3 separator, 4 closing byte, 5 constant nibble
    task automatic build(input bit crc_on, input int len_val, input int fault,
                         input int su_bits, input logic [7:0] salt);
        logic [15:0]   c;
        logic [FB-1:0] d;
        logic [3:0]    nib;
        logic [31:0]   seedw;
        stim.delete();
        seedw = 32'hA5C3_96E1;
        push_field(32'hFF, 8);
        push_field(32'h2, 4);
        push_field(len_val, 24);
        push_field((fault == 3) ? 32'hD : 32'hF, 4);
        c = '0;
        for (int f = 0; f < NF; f++) begin
            stim.push_back((fault == 1 && f == 0) ? 1'b1 : 1'b0);
            d = FB'(seedw >> (f * 8)) ^ FB'(salt);
            for (int i = FB - 1; i >= 0; i--) begin
                stim.push_back(d[i]);
                c = crc_tb(c, d[i]);
            end
            nib = crc_on ? c[3:0] : 4'b0110;
            if (fault == 2 && f == 1) nib = nib ^ 4'b0100;
            if (fault == 5 && f == 0) nib = 4'b0111;
            push_field(32'(nib), 4);
        end
        push_field((fault == 4) ? 32'h7E : 32'h7F, 8);
        for (int i = 0; i < su_bits; i++) stim.push_back(i[0]);
    endtask

    task automatic send_serial(input int gap_every);
        for (int i = 0; i < stim.size(); i++) begin
            @(negedge clk);
            bit_en = 1'b1; bit_in = stim[i];
            if (gap_every > 0 && (i % gap_every) == 0) begin
                @(negedge clk);
                bit_en = 1'b0; bit_in = ~stim[i];
            end
        end
        @(negedge clk);
        bit_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_bytes(input bit poke_busy);
        logic [7:0] bv;
        while (stim.size() % 8 != 0) stim.push_back(1'b1);
        for (int j = 0; j < stim.size() / 8; j++) begin
            for (int k = 0; k < 8; k++) bv[k] = stim[j * 8 + k];
            @(negedge clk);
            byte_valid = 1'b1; byte_in = bv;
            for (int w = 0; w < 7; w++) begin
                @(negedge clk);
                byte_valid = (poke_busy && w == 2) ? 1'b1 : 1'b0;
                byte_in = (poke_busy && w == 2) ? 8'h00 : bv;
            end
        end
        @(negedge clk);
        byte_valid = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bit_en = 1'b0; byte_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        strobes = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_eq("R10 reset err_n", err_n, 1);
        expect_eq("R10 reset done", done, 0);
        expect_eq("R10 reset frame_valid", frame_valid, 0);
        expect_eq("R10 reset length_count", length_count, 0);

        // R1: look-alike headers, then a good constant-mode stream with gaps (R12)
        crc_mode = 1'b0;
        stim.delete();
        push_field(32'h7F, 7); push_field(32'h2, 4);
        push_field(32'hFF, 8); push_field(32'h3, 4);
        send_serial(3);
        expect_eq("R1 no error on look-alike header", err_n, 1);
        expect_eq("R1 no lock on look-alike header", length_count, 0);
        build(1'b0, LEN_OK, 0, SU, 8'h00);
        send_serial(5);
        expect_eq("R2 length word captured", length_count, LEN_OK);
        expect_eq("R5 constant check passes", err_n, 1);
        expect_eq("R7 frame strobes", strobes, NF);
        expect_eq("R12 gaps ignored, done", done, 1);

        // R6 good CRC stream, R9 start-up count boundary
        do_reset();
        crc_mode = 1'b1;
        build(1'b1, LEN_OK, 0, SU - 1, 8'h3C);
        send_serial(0);
        expect_eq("R9 done low one bit short", done, 0);
        expect_eq("R6 crc stream accepted", err_n, 1);
        stim.delete(); stim.push_back(1'b0);
        send_serial(0);
        expect_eq("R9 done after last start-up bit", done, 1);
        expect_eq("R6 crc frame strobes", strobes, NF);

        // R6 wrong CRC nibble, R10 fault holds until reset
        do_reset();
        build(1'b1, LEN_OK, 2, SU, 8'h5A);
        send_serial(0);
        expect_eq("R6 bad crc nibble flagged", err_n, 0);
        expect_eq("R10 strobes stop at fault", strobes, 1);
        build(1'b1, LEN_OK, 0, SU, 8'h5A);
        send_serial(0);
        expect_eq("R10 fault held", err_n, 0);
        expect_eq("R10 no done in fault", done, 0);
        do_reset();
        expect_eq("R10 reset clears fault", err_n, 1);

        // R4 bad start bit
        crc_mode = 1'b0;
        build(1'b0, LEN_OK, 1, SU, 8'h11);
        send_serial(0);
        expect_eq("R4 bad start bit flagged", err_n, 0);
        expect_eq("R4 no strobes", strobes, 0);

        // R3 bad separator
        do_reset();
        build(1'b0, LEN_OK, 3, SU, 8'h22);
        send_serial(0);
        expect_eq("R3 bad separator flagged", err_n, 0);

        // R5 wrong constant
        do_reset();
        build(1'b0, LEN_OK, 5, SU, 8'h33);
        send_serial(0);
        expect_eq("R5 bad constant flagged", err_n, 0);

        // R8 bad closing byte and wrong length word
        do_reset();
        build(1'b0, LEN_OK, 4, SU, 8'h44);
        send_serial(0);
        expect_eq("R8 bad closing byte flagged", err_n, 0);
        expect_eq("R8 frames before closing byte", strobes, NF);
        do_reset();
        build(1'b0, LEN_OK - 1, 0, SU, 8'h55);
        send_serial(0);
        expect_eq("R8 length mismatch flagged", err_n, 0);
        expect_eq("R8 no done on length mismatch", done, 0);

        // R11 byte mode with an extra offer while busy
        do_reset();
        byte_mode = 1'b1;
        build(1'b0, LEN_OK, 0, SU, 8'h66);
        send_bytes(1'b1);
        expect_eq("R11 byte stream done", done, 1);
        expect_eq("R11 byte stream strobes", strobes, NF);
        expect_eq("R11 byte stream length", length_count, LEN_OK);
        byte_mode = 1'b0;

        finish_run();
    end
endmodule